// File: doc/BRIEF.md
# Thermal Clock Throttle Controller

This block decides how much of the time the core clock runs, and which operating point the core is told to use. Software can ask for on-demand clock modulation with a 3-bit duty code in steps of one eighth. A thermal monitor overrides that request while the core is hot. Depending on the selected thermal mode, the monitor either gates the clock at a fixed half rate or moves the core to a fallback operating point.

The over-temperature flag arrives asynchronously. It passes through a synchronizer before any logic uses it. Every change of the synchronized flag raises a one-cycle interrupt pulse, in both directions. Requested operating points are written with a load strobe and held. While the core is hot, a new request is stored but does not reach the output. When the core cools, the output returns to the newest stored request.

All pins are plain control and status levels. No pin carries a data stream, so no pin has a valid/ready handshake.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: With `od_en` high and no halving override, a `duty_code` value N from 1 to 7 makes `core_clk_en` high for exactly N of every 8 consecutive cycles.
- R2: The duty code value 0 is reserved. With `od_en` high and code 0, `core_clk_en` stays high in every cycle.
- R3: With `od_en` low and no halving override, `core_clk_en` stays high in every cycle.
- R4: With `therm_mode` = 2'b01 (halving), the synchronized hot flag makes `core_clk_en` high for exactly 4 of every 8 cycles. This holds whatever `od_en` and `duty_code` are.
- R5: In halving mode, once the synchronized hot flag clears, gating follows `od_en` and `duty_code` again, as in R1 to R3.
- R6: With `therm_mode` = 2'b10 (operating point), the synchronized hot flag sets `opp_out` to `fallback_opp`. The clock is not halved in this mode.
- R7: In operating-point mode, when the synchronized hot flag clears, `opp_out` returns to the most recently loaded request.
- R8: A request loaded while the override is active is stored, but `opp_out` keeps showing `fallback_opp` until the flag clears.
- R9: With `therm_mode` = 2'b11 (both supported), the block behaves as in operating-point mode: fallback point, no halving.
- R10: With `therm_mode` = 2'b00, the thermal monitor is off. The hot flag does not affect `core_clk_en` or `opp_out`.
- R11: `therm_irq` is high for exactly one cycle on each rising edge and each falling edge of the synchronized hot flag. The pulse is visible after the second rising clock edge that samples the changed `hot_async`.
- R12: After reset, `core_clk_en` is 1, `opp_out` is 0 and `therm_irq` is 0.
- R13: When `req_we` is high at a clock edge, `req_opp` is stored. With no override active, it appears on `opp_out` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_async | input | 1 | Over-temperature flag, asynchronous |
| therm_mode | input | 2 | bit0: halving supported, bit1: operating-point drop supported |
| od_en | input | 1 | On-demand modulation enable |
| duty_code | input | 3 | On-demand duty in eighths (0 reserved) |
| req_we | input | 1 | Load strobe for the requested operating point |
| req_opp | input | 4 | Requested operating-point index |
| fallback_opp | input | 4 | Operating point used while hot in operating-point mode |
| core_clk_en | output | 1 | Per-cycle core clock enable |
| opp_out | output | 4 | Operating-point index in force |
| therm_irq | output | 1 | One-cycle pulse on each thermal edge |

## Verification
The assertions check several things on every cycle:
- a full clock when nothing asks for gating;
- the on and off phases of the halved window while hot;
- the fallback point while hot in operating-point mode;
- the return to the stored request on cooling;
- the precedence of operating-point mode when both modes are set;
- an interrupt on each synchronized edge.

Only the bench scenarios can show the things that need a count or a history. These are the exact count of enabled cycles per 8-cycle window for each duty code, the two-edge delay of the interrupt after the input changes, and the request written while hot surfacing only after cooling.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    THR_OFF   = 2'd0,
    THR_HALVE = 2'd1,
    THR_OPP   = 2'd2
  } therm_sel_e;

  // Operating-point drop wins when both capabilities are present.
  function automatic therm_sel_e thr_decode(input logic [1:0] caps);
    if (caps[1])      return THR_OPP;
    else if (caps[0]) return THR_HALVE;
    else              return THR_OFF;
  endfunction
endpackage

// File: rtl/thr_hot_sync.sv
module thr_hot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_async,
  output logic hot_s,
  output logic hot_edge
);
  logic [STAGES-1:0] sh;
  logic              hot_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= hot_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sh[g] <= 1'b0;
          else        sh[g] <= sh[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) hot_prev <= 1'b0;
    else        hot_prev <= sh[STAGES-1];
  end

  assign hot_s    = sh[STAGES-1];
  assign hot_edge = sh[STAGES-1] ^ hot_prev;

  assert_irq_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_s) |-> hot_edge);
  assert_irq_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hot_s) |-> hot_edge);
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hot_s) && $stable(hot_prev) && !hot_edge |=> $stable(hot_s) || hot_edge);
endmodule

// File: rtl/thr_duty_gate.sv
module thr_duty_gate #(
  parameter int DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halve_hot,
  input  logic              od_en,
  input  logic [DUTY_W-1:0] duty,
  output logic              clk_en
);
  localparam int WIN  = 1 << DUTY_W;
  localparam int HALF = WIN / 2;
  localparam int CW   = DUTY_W + 1;

  logic [DUTY_W-1:0] cnt;
  logic [CW-1:0]     on_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (halve_hot)                   on_cycles = CW'(HALF);
    else if (od_en && (duty != '0))  on_cycles = {1'b0, duty};
    else                             on_cycles = CW'(WIN);
  end

  assign clk_en = ({1'b0, cnt} < on_cycles);

  assert_full_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !halve_hot && !od_en |-> clk_en);
  assert_reserved_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !halve_hot && od_en && duty == '0 |-> clk_en);
  assert_halve_on_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halve_hot && cnt == '0 |-> clk_en);
  assert_halve_off_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halve_hot && cnt == DUTY_W'(HALF) |-> !clk_en);
endmodule

// File: rtl/thr_opp_sel.sv
module thr_opp_sel #(
  parameter int             OPP_W   = 4,
  parameter logic [OPP_W-1:0] OPP_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opp_hot,
  input  logic             req_we,
  input  logic [OPP_W-1:0] req_opp,
  input  logic [OPP_W-1:0] fallback,
  output logic [OPP_W-1:0] opp_out
);
  logic [OPP_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)      held <= OPP_RST;
    else if (req_we) held <= req_opp;
  end

  assign opp_out = opp_hot ? fallback : held;

  assert_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    opp_hot |-> opp_out == fallback);
  assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(opp_hot) |-> opp_out == held);
  assert_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    req_we && !opp_hot |=> opp_hot || opp_out == $past(req_opp));
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int DUTY_W      = 3,
  parameter int OPP_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hot_async,
  input  logic [1:0]        therm_mode,
  input  logic              od_en,
  input  logic [DUTY_W-1:0] duty_code,
  input  logic              req_we,
  input  logic [OPP_W-1:0]  req_opp,
  input  logic [OPP_W-1:0]  fallback_opp,
  output logic              core_clk_en,
  output logic [OPP_W-1:0]  opp_out,
  output logic              therm_irq
);
  therm_sel_e sel;
  logic       hot_s;
  logic       halve_hot;
  logic       opp_hot;

  assign sel       = thr_decode(therm_mode);
  assign halve_hot = hot_s && (sel == THR_HALVE);
  assign opp_hot   = hot_s && (sel == THR_OPP);

  thr_hot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hot_async(hot_async),
    .hot_s(hot_s), .hot_edge(therm_irq)
  );

  thr_duty_gate #(.DUTY_W(DUTY_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .halve_hot(halve_hot),
    .od_en(od_en), .duty(duty_code), .clk_en(core_clk_en)
  );

  thr_opp_sel #(.OPP_W(OPP_W), .OPP_RST('0)) u_opp (
    .clk(clk), .rst_n(rst_n), .opp_hot(opp_hot),
    .req_we(req_we), .req_opp(req_opp), .fallback(fallback_opp),
    .opp_out(opp_out)
  );

  assert_both_no_halve_R9: assert property (@(posedge clk) disable iff (!rst_n)
    therm_mode == 2'b11 && !od_en |-> core_clk_en);
  assert_both_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    therm_mode == 2'b11 && hot_s |-> opp_out == fallback_opp);
  assert_off_no_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    therm_mode == 2'b00 && !od_en |-> core_clk_en);
  assert_opp_no_halve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    therm_mode == 2'b10 && !od_en |-> core_clk_en);
endmodule

// File: tb/tb_thermal_throttle_ctrl.sv
module tb_thermal_throttle_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hot_async = 1'b0;
  logic [1:0] therm_mode = 2'b00;
  logic       od_en = 1'b0;
  logic [2:0] duty_code = 3'd0;
  logic       req_we = 1'b0;
  logic [3:0] req_opp = 4'd0;
  logic [3:0] fallback_opp = 4'd9;
  logic       core_clk_en;
  logic [3:0] opp_out;
  logic       therm_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermal_throttle_ctrl dut (
    .clk(clk), .rst_n(rst_n), .hot_async(hot_async), .therm_mode(therm_mode),
    .od_en(od_en), .duty_code(duty_code), .req_we(req_we), .req_opp(req_opp),
    .fallback_opp(fallback_opp), .core_clk_en(core_clk_en), .opp_out(opp_out),
    .therm_irq(therm_irq)
  );

  // {req[14:11], mode[10:9], hot[8], od_en[7], duty[6:4], expected on-cycles[3:0]}
  localparam logic [14:0] VEC [12] = '{
    {4'd3,  2'b00, 1'b0, 1'b0, 3'd0, 4'd8}, // R3 idle
    {4'd1,  2'b00, 1'b0, 1'b1, 3'd1, 4'd1}, // R1
    {4'd1,  2'b00, 1'b0, 1'b1, 3'd3, 4'd3}, // R1
    {4'd1,  2'b00, 1'b0, 1'b1, 3'd7, 4'd7}, // R1
    {4'd2,  2'b00, 1'b0, 1'b1, 3'd0, 4'd8}, // R2 reserved code
    {4'd4,  2'b01, 1'b1, 1'b1, 3'd7, 4'd4}, // R4 override of code 7
    {4'd4,  2'b01, 1'b1, 1'b0, 3'd0, 4'd4}, // R4 with on-demand off
    {4'd5,  2'b01, 1'b0, 1'b1, 3'd5, 4'd5}, // R5 cooled
    {4'd6,  2'b10, 1'b1, 1'b0, 3'd0, 4'd8}, // R6 no halving
    {4'd9,  2'b11, 1'b1, 1'b1, 3'd2, 4'd2}, // R9 priority
    {4'd10, 2'b00, 1'b1, 1'b0, 3'd0, 4'd8}, // R10 monitor off
    {4'd5,  2'b01, 1'b0, 1'b0, 3'd3, 4'd8}  // R5 cooled, on-demand off
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_window(output int ones);
    ones = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (core_clk_en) ones++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int ones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk(core_clk_en == 1'b1, "R12", int'(core_clk_en), 1);
    chk(opp_out == 4'd0, "R12", int'(opp_out), 0);
    chk(therm_irq == 1'b0, "R12", int'(therm_irq), 0);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      therm_mode = VEC[i][10:9];
      hot_async  = VEC[i][8];
      od_en      = VEC[i][7];
      duty_code  = VEC[i][6:4];
      repeat (4) @(negedge clk);
      count_window(ones);
      chk(ones == int'(VEC[i][3:0]), $sformatf("R%0d", VEC[i][14:11]),
          ones, int'(VEC[i][3:0]));
    end

    // R11 interrupt timing on rise and fall
    @(negedge clk);
    therm_mode = 2'b00; od_en = 1'b0; hot_async = 1'b0;
    repeat (4) @(negedge clk);
    hot_async = 1'b1;
    @(negedge clk); chk(therm_irq == 1'b0, "R11 rise early", int'(therm_irq), 0);
    @(negedge clk); chk(therm_irq == 1'b1, "R11 rise pulse", int'(therm_irq), 1);
    @(negedge clk); chk(therm_irq == 1'b0, "R11 rise end", int'(therm_irq), 0);
    hot_async = 1'b0;
    @(negedge clk); chk(therm_irq == 1'b0, "R11 fall early", int'(therm_irq), 0);
    @(negedge clk); chk(therm_irq == 1'b1, "R11 fall pulse", int'(therm_irq), 1);
    @(negedge clk); chk(therm_irq == 1'b0, "R11 fall end", int'(therm_irq), 0);

    // R13 request load with no override
    therm_mode = 2'b10;
    req_opp = 4'd5; req_we = 1'b1;
    @(negedge clk); req_we = 1'b0;
    chk(opp_out == 4'd5, "R13", int'(opp_out), 5);

    // R6 fallback while hot
    hot_async = 1'b1;
    repeat (4) @(negedge clk);
    chk(opp_out == 4'd9, "R6", int'(opp_out), 9);

    // R8 request while hot is held back
    req_opp = 4'd3; req_we = 1'b1;
    @(negedge clk); req_we = 1'b0;
    repeat (2) @(negedge clk);
    chk(opp_out == 4'd9, "R8 held", int'(opp_out), 9);

    // R7 return to newest request on cooling
    hot_async = 1'b0;
    repeat (4) @(negedge clk);
    chk(opp_out == 4'd3, "R7", int'(opp_out), 3);

    // R9 both capabilities: fallback point
    therm_mode = 2'b11; hot_async = 1'b1;
    repeat (4) @(negedge clk);
    chk(opp_out == 4'd9, "R9", int'(opp_out), 9);

    // R10 monitor off: hot leaves the point alone
    therm_mode = 2'b00;
    repeat (2) @(negedge clk);
    chk(opp_out == 4'd3, "R10", int'(opp_out), 3);

    // R4 halving ignores the point; point stays at request
    therm_mode = 2'b01;
    repeat (2) @(negedge clk);
    chk(opp_out == 4'd3, "R4 point unchanged", int'(opp_out), 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule